// File: doc/BRIEF.md
# Single-Precision Rounding and Exception Unit

This block is the last step of a floating-point datapath. An arithmetic stage delivers its exact result as a sign, a signed unbiased exponent, a normalised 64-bit significand and two bits, guard and sticky, that stand for everything below the significand. The block rounds that value to the packed 32-bit single-precision format in one of four directions. It also raises the events that a status register collects: overflow, tininess, loss of accuracy, underflow and inexact.

Overflow and tininess are judged on the rounded value, taken as if the exponent range had no bound. As a result, the rounding mode decides whether a value near either edge of the range raises an event at all. On overflow the returned value is either a signed infinity or the largest finite number, depending on the mode. Two trap-enable inputs change the returned value and the inexact event.

Results below the normal range are shifted into denormal form. The bits shifted out are folded into sticky, and the value is then rounded again. One register stage sits between the input and the output, marked by a valid bit on each side.

Top module: `fp32r_round_unit`

## Requirements
- R1: The input value is (-1)^in_sign × in_mant × 2^(in_exp−63), followed by in_guard with weight 2^(in_exp−64) and by in_sticky below that. in_mant bit 63 is set for any nonzero input. Mode 0 rounds to nearest. A value exactly halfway between two representable values goes to the one whose last significand bit is 0.
- R2: Mode 1 rounds toward plus infinity, mode 2 toward minus infinity and mode 3 toward zero. Guard and sticky take part in the rounding.
- R3: When no trap is taken, out_inexact is set if the returned value differs from the exact input value. It is clear when the two are equal.
- R4: out_ovf is set when the value rounded to 24 significand bits, with no exponent limit, has a biased exponent above 254. A value just below 2^128 therefore overflows only in modes that round it up.
- R5: With the overflow trap disabled, an overflow returns a result chosen by mode and sign. Mode 0 returns infinity and mode 3 the largest finite value (magnitude 0x7F7FFFFF). Mode 1 returns +infinity for a positive result and −max for a negative one. Mode 2 is the mirror of mode 1. out_inexact is set.
- R6: With in_trap_ofl set, an overflow returns a signed infinity (magnitude 0x7F800000), and out_inexact stays clear.
- R7: out_tiny is set when a nonzero value rounded to 24 bits with no exponent limit is smaller than 2^−126. A result below the normal range is packed with exponent field 0. A result that rounds up to 2^−126 is packed with exponent field 1.
- R8: out_loss is set when out_tiny is set and the denormal result differs from the exact value. out_ufl equals out_tiny AND (in_trap_ufl OR out_loss).
- R9: With in_trap_ufl set, a tiny result returns a zero carrying the input sign, and out_inexact stays clear.
- R10: An all-zero in_mant returns a zero carrying the input sign, with every event clear.
- R11: Outputs are registered. A valid input appears one clock later together with out_valid. When in_valid is low, out_valid drops and the result holds its value. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value present |
| in_sign | input | 1 | Sign of the exact value |
| in_exp | input | EXP_W (16) | Signed unbiased exponent of significand bit 63 |
| in_mant | input | MANT_W (64) | Normalised significand |
| in_guard | input | 1 | Bit just below the significand |
| in_sticky | input | 1 | OR of all bits below the guard bit |
| in_mode | input | 2 | Rounding direction (0 nearest, 1 up, 2 down, 3 toward zero) |
| in_trap_ofl | input | 1 | Overflow trap enable |
| in_trap_ufl | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Packed single-precision result |
| out_ovf | output | 1 | Overflow event |
| out_tiny | output | 1 | Tininess event |
| out_loss | output | 1 | Loss-of-accuracy event |
| out_ufl | output | 1 | Underflow flag event |
| out_inexact | output | 1 | Inexact event |

## Verification
The assertions check on every cycle the rules that hold regardless of the data. An overflow returns only infinity or the largest finite magnitude. A tiny result never carries an exponent field above 1. Loss and underflow never appear without tininess, and overflow and tininess never appear together. Mode 3 never returns infinity without a trap. The one-cycle valid pipeline and the holding of the result are also checked every cycle. Only the bench scenarios can show the exact bit patterns: tie-to-even against tie-to-odd, each directed mode on both signs, whether overflow appears depending on the mode, the tiny value that still rounds up to the smallest normal, the cap on deep shifts, and the values returned under each trap.

// File: rtl/fp32r_pkg.sv
package fp32r_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_UP   = 2'd1,
    RM_DOWN = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  localparam int SIG_W  = 24;
  localparam int FRAC_W = SIG_W - 1;
  localparam int EXPF_W = 8;
  localparam int MAG_W  = EXPF_W + FRAC_W;
  localparam int BIAS   = 127;
  localparam int EMAX   = 127;
  localparam int EMIN   = -126;

  localparam logic [MAG_W-1:0] INF_MAG = 31'h7F80_0000;
  localparam logic [MAG_W-1:0] MAX_MAG = 31'h7F7F_FFFF;

  // Whether the kept significand must step up by one unit in the last place.
  function automatic logic rnd_incr(rmode_e m, logic neg, logic lsb, logic r, logic s);
    case (m)
      RM_NEAR: return r & (s | lsb);
      RM_UP:   return ~neg & (r | s);
      RM_DOWN: return neg & (r | s);
      default: return 1'b0;
    endcase
  endfunction

  // Magnitude returned on overflow.
  function automatic logic [MAG_W-1:0] ovf_mag(rmode_e m, logic neg, logic trap);
    if (trap) return INF_MAG;
    case (m)
      RM_NEAR: return INF_MAG;
      RM_UP:   return neg ? MAX_MAG : INF_MAG;
      RM_DOWN: return neg ? INF_MAG : MAX_MAG;
      default: return MAX_MAG;
    endcase
  endfunction

endpackage

// File: rtl/fp32r_sticky_shift.sv
module fp32r_sticky_shift #(
  parameter int W   = 65,
  parameter int SHW = $clog2(W + 1)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   dout,
  output logic           lost
);
  logic [2*W-1:0] wide;

  assign wide = {din, {W{1'b0}}} >> sh;
  assign dout = wide[2*W-1:W];
  assign lost = |wide[W-1:0];
endmodule

// File: rtl/fp32r_round_step.sv
module fp32r_round_step
  import fp32r_pkg::*;
#(
  parameter int SW = SIG_W
) (
  input  logic          neg,
  input  rmode_e        mode,
  input  logic [SW-1:0] sig,
  input  logic          rbit,
  input  logic          sbit,
  output logic [SW:0]   sig_r,
  output logic          inexact
);
  logic up;

  always_comb begin
    up    = rnd_incr(mode, neg, sig[0], rbit, sbit);
    sig_r = {1'b0, sig} + {{SW{1'b0}}, up};
  end

  assign inexact = rbit | sbit;
endmodule

// File: rtl/fp32r_ovf_select.sv
module fp32r_ovf_select
  import fp32r_pkg::*;
(
  input  logic             neg,
  input  rmode_e           mode,
  input  logic             trap,
  output logic [MAG_W-1:0] mag
);
  assign mag = ovf_mag(mode, neg, trap);
endmodule

// File: rtl/fp32r_round_unit.sv
module fp32r_round_unit
  import fp32r_pkg::*;
#(
  parameter int EXP_W  = 16,
  parameter int MANT_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_guard,
  input  logic                    in_sticky,
  input  logic [1:0]              in_mode,
  input  logic                    in_trap_ofl,
  input  logic                    in_trap_ufl,
  output logic                    out_valid,
  output logic [31:0]             out_result,
  output logic                    out_ovf,
  output logic                    out_tiny,
  output logic                    out_loss,
  output logic                    out_ufl,
  output logic                    out_inexact
);
  localparam int XW    = EXP_W + 2;
  localparam int SW    = MANT_W + 1;
  localparam int SHW   = $clog2(SW + 1);
  localparam int LOW_A = MANT_W - 1 - SIG_W;
  localparam int LOW_D = SW - 1 - SIG_W;
  localparam int PADW  = MAG_W - SIG_W - 1;

  localparam logic signed [XW-1:0] EMIN_X  = XW'(EMIN);
  localparam logic signed [XW-1:0] EMAX_X  = XW'(EMAX);
  localparam logic signed [XW-1:0] BIASM_X = XW'(BIAS - 1);
  localparam logic signed [XW-1:0] SHMAX_X = XW'(SW);

  rmode_e mode;
  assign mode = rmode_e'(in_mode);

  logic signed [XW-1:0] e_x;
  assign e_x = {{2{in_exp[EXP_W-1]}}, in_exp};

  // Path A: rounding to 24 bits with no exponent limit.
  logic [SIG_W:0]       sig_a;
  logic                 inx_a;
  logic signed [XW-1:0] e_a;
  logic [MAG_W-1:0]     mag_a;

  fp32r_round_step #(.SW(SIG_W)) u_round_a (
    .neg     (in_sign),
    .mode    (mode),
    .sig     (in_mant[MANT_W-1 -: SIG_W]),
    .rbit    (in_mant[LOW_A]),
    .sbit    ((|in_mant[LOW_A-1:0]) | in_guard | in_sticky),
    .sig_r   (sig_a),
    .inexact (inx_a)
  );

  assign e_a   = e_x + {{(XW-1){1'b0}}, sig_a[SIG_W]};
  // The hidden bit and a rounding carry add into the exponent field.
  assign mag_a = {EXPF_W'(e_x + BIASM_X), {FRAC_W{1'b0}}} + {{PADW{1'b0}}, sig_a};

  // Path D: denormalising shift, then rounding on the coarser grid.
  logic                 use_d;
  logic signed [XW-1:0] sh_full;
  logic [SHW-1:0]       sh_cap;
  logic [SW-1:0]        shifted;
  logic                 lost_d;
  logic [SIG_W:0]       sig_d;
  logic                 inx_d;
  logic [MAG_W-1:0]     mag_d;

  assign use_d   = e_x < EMIN_X;
  assign sh_full = EMIN_X - e_x;

  always_comb begin
    if (!use_d)                 sh_cap = '0;
    else if (sh_full > SHMAX_X) sh_cap = SHW'(SW);
    else                        sh_cap = sh_full[SHW-1:0];
  end

  fp32r_sticky_shift #(.W(SW), .SHW(SHW)) u_shift (
    .din  ({in_mant, in_guard}),
    .sh   (sh_cap),
    .dout (shifted),
    .lost (lost_d)
  );

  fp32r_round_step #(.SW(SIG_W)) u_round_d (
    .neg     (in_sign),
    .mode    (mode),
    .sig     (shifted[SW-1 -: SIG_W]),
    .rbit    (shifted[LOW_D]),
    .sbit    ((|shifted[LOW_D-1:0]) | lost_d | in_sticky),
    .sig_r   (sig_d),
    .inexact (inx_d)
  );

  // A carry into bit 23 lands in exponent field bit 0: the smallest normal.
  assign mag_d = {{PADW{1'b0}}, sig_d};

  logic [MAG_W-1:0] mag_o;
  fp32r_ovf_select u_ovf (
    .neg  (in_sign),
    .mode (mode),
    .trap (in_trap_ofl),
    .mag  (mag_o)
  );

  // Named events, visible to the assertions.
  logic is_zero, ovf_evt, tiny_evt, loss_evt, ufl_evt, trap_hit, rnd_inx, inx_evt;
  logic [MAG_W-1:0] mag_n;

  assign is_zero  = ~|in_mant;
  assign ovf_evt  = !is_zero && (e_a > EMAX_X);
  assign tiny_evt = !is_zero && (e_a < EMIN_X);
  assign loss_evt = tiny_evt && inx_d;
  assign ufl_evt  = tiny_evt && (in_trap_ufl || loss_evt);
  assign trap_hit = (ovf_evt && in_trap_ofl) || (tiny_evt && in_trap_ufl);
  assign rnd_inx  = use_d ? inx_d : inx_a;
  assign inx_evt  = !is_zero && !trap_hit && (ovf_evt || rnd_inx);

  always_comb begin
    if (is_zero)                       mag_n = '0;
    else if (ovf_evt)                  mag_n = mag_o;
    else if (tiny_evt && in_trap_ufl)  mag_n = '0;
    else if (use_d)                    mag_n = mag_d;
    else                               mag_n = mag_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_ovf     <= 1'b0;
      out_tiny    <= 1'b0;
      out_loss    <= 1'b0;
      out_ufl     <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= {in_sign, mag_n};
        out_ovf     <= ovf_evt;
        out_tiny    <= tiny_evt;
        out_loss    <= loss_evt;
        out_ufl     <= ufl_evt;
        out_inexact <= inx_evt;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result))); // R11
  AST_NO_OVERFLOW_TINY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ovf && out_tiny)); // R4
  AST_OVF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_result[30:0] == INF_MAG || out_result[30:0] == MAX_MAG)); // R5
  AST_ZERO_MODE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_evt && mode == RM_ZERO && !in_trap_ofl) |=> (out_result[30:0] == MAX_MAG)); // R5
  AST_TINY_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tiny) |-> (out_result[30:24] == 7'd0)); // R7
  AST_LOSS_TINY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_loss) |-> out_tiny); // R8
  AST_UFL_TINY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ufl) |-> out_tiny); // R8

endmodule

// File: tb/fp32r_round_unit_test.sv
`timescale 1ns/1ps
module fp32r_round_unit_test;

  typedef struct packed {
    logic        sign;
    logic [15:0] ex;
    logic [63:0] mant;
    logic        g;
    logic        s;
    logic [1:0]  mode;
    logic        tofl;
    logic        tufl;
    logic [31:0] res;
    logic [4:0]  flg;   // {ovf, tiny, loss, ufl, inexact}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 16'h0000, ONE,                    1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3F80_0000, 5'b00000, 4'd1},  // R1 exact
    '{1'b0, 16'hFFF6, 64'hC000_0000_0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3AC0_0000, 5'b00000, 4'd1},  // R1 other exponent
    '{1'b0, 16'h0000, 64'h8000_0080_0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3F80_0000, 5'b00001, 4'd1},  // R1 tie, even kept
    '{1'b0, 16'h0000, 64'h8000_0180_0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3F80_0002, 5'b00001, 4'd1},  // R1 tie, odd up
    '{1'b0, 16'h0000, 64'h8000_0080_0000_0000, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h3F80_0001, 5'b00001, 4'd1},  // R1 above tie
    '{1'b0, 16'h0000, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h3F80_0001, 5'b00001, 4'd2},  // R2 up pos
    '{1'b1, 16'h0000, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'hBF80_0000, 5'b00001, 4'd2},  // R2 up neg
    '{1'b1, 16'h0000, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'hBF80_0001, 5'b00001, 4'd2},  // R2 down neg
    '{1'b0, 16'h0000, 64'h8000_0180_0000_0000, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h3F80_0001, 5'b00001, 4'd2},  // R2 toward zero
    '{1'b0, 16'h0000, ONE,                    1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 32'h3F80_0001, 5'b00001, 4'd3},  // R3 guard only
    '{1'b0, 16'h007F, 64'hFFFF_FF00_0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7F7F_FFFF, 5'b00000, 4'd3},  // R3 exact max
    '{1'b0, 16'h007F, ALL1,                   1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7F80_0000, 5'b10001, 4'd4},  // R4 rounds over
    '{1'b0, 16'h007F, ALL1,                   1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h7F7F_FFFF, 5'b00001, 4'd4},  // R4 stays under
    '{1'b0, 16'h007F, ALL1,                   1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h7F7F_FFFF, 5'b00001, 4'd4},  // R4 down pos
    '{1'b0, 16'h007F, ALL1,                   1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h7F80_0000, 5'b10001, 4'd4},  // R4 up pos
    '{1'b1, 16'h007F, ALL1,                   1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'hFF7F_FFFF, 5'b00001, 4'd4},  // R4 up neg
    '{1'b0, 16'h0080, ONE,                    1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h7F7F_FFFF, 5'b10001, 4'd5},  // R5 down pos
    '{1'b1, 16'h0080, ONE,                    1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'hFF80_0000, 5'b10001, 4'd5},  // R5 down neg
    '{1'b1, 16'h0080, ONE,                    1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'hFF7F_FFFF, 5'b10001, 4'd5},  // R5 up neg
    '{1'b1, 16'h0080, ONE,                    1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 32'hFF7F_FFFF, 5'b10001, 4'd5},  // R5 zero neg
    '{1'b1, 16'h0080, ONE,                    1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'hFF80_0000, 5'b10000, 4'd6},  // R6 trap
    '{1'b0, 16'h00C8, ONE,                    1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 32'h7F80_0000, 5'b10000, 4'd6},  // R6 trap, mode 3
    '{1'b0, 16'hFF81, ONE,                    1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0040_0000, 5'b01000, 4'd7},  // R7 exact denormal
    '{1'b0, 16'hFF6B, ONE,                    1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0001, 5'b01000, 4'd7},  // R7 smallest denormal
    '{1'b0, 16'hFF81, ALL1,                   1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0080_0000, 5'b00001, 4'd7},  // R7 not tiny after rounding
    '{1'b0, 16'hFF81, 64'hFFFF_FF40_0000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0080_0000, 5'b01111, 4'd7},  // R7 tiny, packs exp 1
    '{1'b0, 16'hFF6A, ONE,                    1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 5'b01111, 4'd8},  // R8 half of min, to zero
    '{1'b0, 16'hFF6A, ONE,                    1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_0001, 5'b01111, 4'd8},  // R8 half of min, up
    '{1'b0, 16'hFED4, ONE,                    1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_0001, 5'b01111, 4'd8},  // R8 deep shift cap
    '{1'b1, 16'hFF81, ONE,                    1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h8000_0000, 5'b01010, 4'd9},  // R9 trap, exact
    '{1'b0, 16'hFF6A, ONE,                    1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h0000_0000, 5'b01110, 4'd9},  // R9 trap, lossy
    '{1'b1, 16'h0005, 64'h0,                  1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 32'h8000_0000, 5'b00000, 4'd10}  // R10 zero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic        in_guard = 1'b0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_mode = '0;
  logic        in_trap_ofl = 1'b0;
  logic        in_trap_ufl = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ovf, out_tiny, out_loss, out_ufl, out_inexact;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fp32r_round_unit uut (
    .clk, .rst_n, .in_valid, .in_sign, .in_exp, .in_mant, .in_guard, .in_sticky,
    .in_mode, .in_trap_ofl, .in_trap_ufl, .out_valid, .out_result,
    .out_ovf, .out_tiny, .out_loss, .out_ufl, .out_inexact
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] flags();
    return {out_ovf, out_tiny, out_loss, out_ufl, out_inexact};
  endfunction

  task automatic drive(input vec_t v);
    in_valid    = 1'b1;
    in_sign     = v.sign;
    in_exp      = v.ex;
    in_mant     = v.mant;
    in_guard    = v.g;
    in_sticky   = v.s;
    in_mode     = v.mode;
    in_trap_ofl = v.tofl;
    in_trap_ufl = v.tufl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0 && out_result == 32'h0 && flags() == 5'b0, "R11 reset",
          {out_valid, flags(), out_result[25:0]}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check(out_valid == 1'b1, $sformatf("R11 valid vec %0d", i), {31'b0, out_valid}, 32'h1);
      check(out_result == VECS[i].res, $sformatf("R%0d result vec %0d", VECS[i].req, i),
            out_result, VECS[i].res);
      check(flags() == VECS[i].flg, $sformatf("R%0d flags vec %0d", VECS[i].req, i),
            {27'b0, flags()}, {27'b0, VECS[i].flg});
      in_valid = 1'b0;
    end

    // R11: idle input leaves result held and valid low
    @(negedge clk);
    drive(VECS[3]);
    @(negedge clk);
    held = out_result;
    in_valid = 1'b0;
    in_mant  = ALL1;
    in_exp   = 16'h0080;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 valid drops", {31'b0, out_valid}, 32'h0);
    check(out_result == held, "R11 result held", out_result, held);
    @(negedge clk);
    check(out_result == 32'h3F80_0002, "R11 still held", out_result, 32'h3F80_0002);

    // R11: back-to-back inputs, each one cycle late
    drive(VECS[0]);
    @(negedge clk);
    check(out_result == 32'h3F80_0000, "R11 b2b first", out_result, 32'h3F80_0000);
    drive(VECS[17]);
    @(negedge clk);
    check(out_result == 32'hFF80_0000, "R11 b2b second", out_result, 32'hFF80_0000);
    check(flags() == 5'b10001, "R5 b2b flags", {27'b0, flags()}, 32'h11);

    // R11: reset during operation clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_result == 32'h0 && flags() == 5'b0, "R11 mid reset",
          {out_valid, flags(), out_result[25:0]}, 32'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule